// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block moves a programmed number of words between one I/O device and memory while the CPU stays off the bus. Software loads a start address, a word count and a mode through a small register port. That port answers only while its select is high. Software then sets the start bit. When the device raises its request, the controller asks the CPU for the bus. Once the CPU grants it, the controller performs one memory cycle per word and acknowledges the device during that cycle.

Each word advances the address by one and lowers the count by one. The last word raises a sticky end-of-transfer interrupt and releases the bus. Two release policies are available. In burst mode the bus is held from the first word to the last. In cycle-stealing mode the bus is handed back after every word and requested again for the next one. The address and data drive enables are low whenever the grant is not held.

Top module: `dma_ctrl`

## Requirements
- R1: Register writes take effect only when sel_i and wr_i are both high. The read data is zero unless sel_i and rd_i are both high. The reg_i codes are: 0 address, 1 word count, 2 mode, 3 status. Status bit 0 is the end-of-transfer flag.
- R2: Mode register bits: bit 0 is start, bit 1 is direction (1 = memory to device, 0 = device to memory), bit 2 is burst (1 = burst, 0 = cycle stealing).
- R3: With start set, a nonzero count and dev_req_i high, bus_req_o rises. No acknowledge and no memory strobe occur unless bus_gnt_i is high.
- R4: In device-to-memory mode, each word cycle asserts dev_ack_o and mem_we_o for one cycle. mem_wdata_o equals dev_wdata_i and mem_addr_o equals the current address.
- R5: In memory-to-device mode, each word cycle asserts dev_ack_o and mem_re_o. dev_rdata_o equals mem_rdata_i for the current address.
- R6: After each word the address increments by one, modulo 2^AW, and the count decrements by one.
- R7: When the count reaches zero, the interrupt is set, the start bit clears and bus_req_o falls.
- R8: In burst mode bus_req_o stays high from its first rise until the last word.
- R9: In cycle-stealing mode bus_req_o is low in the cycle after every word.
- R10: addr_oe_o and data_oe_o are low whenever bus_gnt_i is low. data_oe_o is high only on device-to-memory word cycles.
- R11: The interrupt stays set until a write to the mode register clears it.
- R12: Setting start with a count of zero never raises bus_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register port select |
| reg_i | input | 2 | Register index |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data |
| dev_req_i | input | 1 | Device transfer request |
| dev_ack_o | output | 1 | Device acknowledge |
| dev_wdata_i | input | DW | Word from device |
| dev_rdata_o | output | DW | Word to device |
| bus_req_o | output | 1 | Bus request to CPU |
| bus_gnt_i | input | 1 | Bus grant from CPU |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| addr_oe_o | output | 1 | Address bus drive enable |
| data_oe_o | output | 1 | Data bus drive enable |
| eot_irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The bench grants the bus after random delays and drops the device request at random. A design that strobes memory before the grant is caught on that cycle. So is a design that counts a word when the device was not acknowledged. A design that skips or repeats a word is caught by the address and data checks. Transfers of a single word, a start address near the top of memory that wraps to zero, and a start with a zero count are all run. An off-by-one in the last-word test would show as an early or missing interrupt, or as a request for an empty transfer. Each release policy is watched every cycle: a burst that drops the request too soon fails, and so does a cycle-stealing run that keeps it.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } dma_state_e;

  localparam logic [1:0] RS_ADDR   = 2'd0;
  localparam logic [1:0] RS_COUNT  = 2'd1;
  localparam logic [1:0] RS_MODE   = 2'd2;
  localparam logic [1:0] RS_STATUS = 2'd3;

  localparam int MB_START = 0;
  localparam int MB_DIR   = 1;
  localparam int MB_BURST = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [1:0]    reg_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          start_o,
  output logic          dir_o,
  output logic          burst_o,
  output logic          last_o,
  output logic          cnt_zero_o,
  output logic          eot_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          start_q, dir_q, burst_q, eot_q;
  logic          wr_en, wr_addr, wr_cnt, wr_mode, done;

  assign wr_en   = sel_i && wr_i;
  assign wr_addr = wr_en && (reg_i == RS_ADDR);
  assign wr_cnt  = wr_en && (reg_i == RS_COUNT);
  assign wr_mode = wr_en && (reg_i == RS_MODE);
  assign last_o     = (count_q == CNT_ONE);
  assign cnt_zero_o = (count_q == '0);
  assign done       = step_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (wr_addr) addr_q <= AW'(wdata_i);
    else if (step_i)  addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (wr_cnt)  count_q <= CW'(wdata_i);
    else if (step_i)  count_q <= count_q - CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      eot_q   <= 1'b0;
    end else if (wr_mode) begin
      start_q <= wdata_i[MB_START];
      dir_q   <= wdata_i[MB_DIR];
      burst_q <= wdata_i[MB_BURST];
      eot_q   <= 1'b0;
    end else if (done) begin
      start_q <= 1'b0;
      eot_q   <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      unique case (reg_i)
        RS_ADDR:  rdata_o = DW'(addr_q);
        RS_COUNT: rdata_o = DW'(count_q);
        RS_MODE: begin
          rdata_o[MB_START] = start_q;
          rdata_o[MB_DIR]   = dir_q;
          rdata_o[MB_BURST] = burst_q;
        end
        default:  rdata_o[0] = eot_q;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign start_o = start_q;
  assign dir_o   = dir_q;
  assign burst_o = burst_q;
  assign eot_o   = eot_q;

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_cnt) |=> (count_q == $past(count_q) - CNT_ONE));
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_addr) |=> (addr_q == $past(addr_q) + 1'b1));
  a_r7_last_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !wr_mode) |=> (eot_q && !start_q && cnt_zero_o));
  a_r11_eot_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> !eot_q);
  a_r11_eot_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_q && !wr_mode) |=> eot_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic burst_i,
  input  logic cnt_zero_i,
  input  logic last_i,
  input  logic dreq_i,
  input  logic bg_i,
  output logic br_o,
  output logic dack_o,
  output logic step_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (start_i && !cnt_zero_i && dreq_i) state_d = ST_WAIT;
      ST_WAIT:
        if (!start_i)             state_d = ST_IDLE;
        else if (bg_i && dreq_i)  state_d = ST_XFER;
      ST_XFER:
        if (!bg_i)                state_d = ST_WAIT;
        else if (last_i)          state_d = ST_IDLE;
        else if (!burst_i)        state_d = ST_IDLE;
        else if (dreq_i)          state_d = ST_XFER;
        else                      state_d = ST_WAIT;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign br_o   = (state_q != ST_IDLE);
  assign dack_o = (state_q == ST_XFER) && bg_i;
  assign step_o = dack_o;

  a_r3_ack_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> ($past(bg_i) && br_o));
  a_r8_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_o && burst_i && start_i && !(step_o && last_i)) |=> br_o);
  a_r9_steal_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !burst_i) |=> !br_o);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [1:0]    reg_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          dev_req_i,
  output logic          dev_ack_o,
  input  logic [DW-1:0] dev_wdata_i,
  output logic [DW-1:0] dev_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic          eot_irq_o
);
  logic step, start, dir, burst, last, cnt_zero;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .reg_i      (reg_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .step_i     (step),
    .addr_o     (mem_addr_o),
    .start_o    (start),
    .dir_o      (dir),
    .burst_o    (burst),
    .last_o     (last),
    .cnt_zero_o (cnt_zero),
    .eot_o      (eot_irq_o)
  );

  dma_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .burst_i    (burst),
    .cnt_zero_i (cnt_zero),
    .last_i     (last),
    .dreq_i     (dev_req_i),
    .bg_i       (bus_gnt_i),
    .br_o       (bus_req_o),
    .dack_o     (dev_ack_o),
    .step_o     (step)
  );

  assign mem_we_o    = step && !dir;
  assign mem_re_o    = step && dir;
  assign mem_wdata_o = dev_wdata_i;
  assign dev_rdata_o = mem_re_o ? mem_rdata_i : '0;
  assign addr_oe_o   = bus_gnt_i && bus_req_o;
  assign data_oe_o   = mem_we_o;

  a_r12_req_needs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cnt_zero);
  a_r10_data_oe_in_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (addr_oe_o && dev_ack_o));
  a_r3_strobe_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> dev_ack_o);
endmodule

// File: tb/dma_ctrl_test.sv
`timescale 1ns/1ps
module dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  rsel = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic        dreq = 1'b0, dack;
  logic [15:0] dev_wd = '0, dev_rd;
  logic        br, bg = 1'b0;
  logic [15:0] maddr, mwdata, mrdata;
  logic        mwe, mre, aoe, doe, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    return (a * 16'd3) ^ 16'h5A5A;
  endfunction

  assign mrdata = mem_val(maddr);

  dma_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .reg_i(rsel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dev_req_i(dreq), .dev_ack_o(dack),
    .dev_wdata_i(dev_wd), .dev_rdata_o(dev_rd), .bus_req_o(br), .bus_gnt_i(bg),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .mem_we_o(mwe), .mem_re_o(mre), .addr_oe_o(aoe), .data_oe_o(doe), .eot_irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] r, input logic [15:0] v, input bit cs);
    @(negedge clk);
    sel = cs; wr = 1'b1; rsel = r; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] r, input bit cs, output logic [15:0] v);
    @(negedge clk);
    sel = cs; rd = 1'b1; rsel = r;
    #1 v = rdata;
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic run_xfer(input bit dir, input bit burst, input logic [15:0] base, input int n);
    int k = 0;
    bit prev_ack = 1'b0;
    bit seen_req = 1'b0;
    logic [15:0] v;
    reg_wr(2'd0, base, 1'b1);
    reg_wr(2'd1, 16'(n), 1'b1);
    reg_wr(2'd2, {13'd0, burst, dir, 1'b1}, 1'b1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!bg) chk(!aoe && !doe, "R10 enables without grant", {aoe, doe}, 0);
      if ((dack || mwe || mre) && !bg) chk(1'b0, "R3 activity without grant", {dack, mwe, mre}, 0);
      if (burst && k > 0 && k < n) chk(br, "R8 burst request held", br, 1);
      if (!burst && prev_ack && k < n) chk(!br, "R9 steal release", br, 0);
      if (br) seen_req = 1'b1;
      prev_ack = dack;
      if (dack) begin
        chk(k < n, "R6 extra word", k, n);
        chk(maddr == base + 16'(k), "R6 address", maddr, base + 16'(k));
        if (!dir) begin
          chk(mwe && !mre && doe, "R4 write strobe", {mwe, mre, doe}, 3'b101);
          chk(mwdata == dev_wd, "R4 write data", mwdata, dev_wd);
        end else begin
          chk(mre && !mwe && !doe, "R5 read strobe", {mwe, mre, doe}, 3'b010);
          chk(dev_rd == mem_val(base + 16'(k)), "R5 read data", dev_rd, mem_val(base + 16'(k)));
        end
        k++;
      end else if (k == n) begin
        break;
      end
      dreq   = ($urandom % 4) != 0;
      bg     = br ? (bg | ($urandom % 2 == 0)) : 1'b0;
      dev_wd = 16'($urandom);
    end
    dreq = 1'b0;
    chk(k == n, "R6 word total", k, n);
    chk(seen_req, "R3 request raised", seen_req, 1);
    chk(!br && irq, "R7 completion", {br, irq}, 2'b01);
    bg = 1'b0;
    reg_rd(2'd1, 1'b1, v);
    chk(v == 16'd0, "R6 count at end", v, 0);
    reg_rd(2'd0, 1'b1, v);
    chk(v == base + 16'(n), "R6 address at end", v, base + 16'(n));
    reg_rd(2'd2, 1'b1, v);
    chk(v == {13'd0, burst, dir, 1'b0}, "R7 start cleared", v, {13'd0, burst, dir, 1'b0});
    reg_rd(2'd3, 1'b1, v);
    chk(v == 16'd1, "R11 status flag", v, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(!br && !dack && !irq && !aoe && !doe, "R1 reset outputs", {br, dack, irq, aoe, doe}, 0);
    reg_rd(2'd3, 1'b1, v);
    chk(v == 16'd0, "R1 reset status", v, 0);

    // R1 select gating
    reg_wr(2'd0, 16'h1234, 1'b1);
    reg_rd(2'd0, 1'b1, v);
    chk(v == 16'h1234, "R1 address readback", v, 16'h1234);
    reg_wr(2'd0, 16'hBEEF, 1'b0);
    reg_rd(2'd0, 1'b1, v);
    chk(v == 16'h1234, "R1 write without select", v, 16'h1234);
    reg_rd(2'd0, 1'b0, v);
    chk(v == 16'h0, "R1 read without select", v, 0);
    reg_wr(2'd2, 16'h0006, 1'b1);
    reg_rd(2'd2, 1'b1, v);
    chk(v == 16'h0006, "R2 mode readback", v, 16'h0006);

    // R12 zero count
    reg_wr(2'd1, 16'd0, 1'b1);
    reg_wr(2'd2, 16'h0001, 1'b1);
    dreq = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (br) chk(1'b0, "R12 request with zero count", br, 0);
    end
    chk(!br && !irq, "R12 idle after zero count", {br, irq}, 0);
    dreq = 1'b0;

    // directed transfers: R2 R4 R5 R8 R9
    run_xfer(1'b0, 1'b1, 16'h0100, 6);
    repeat (5) @(negedge clk);
    chk(irq, "R11 flag holds", irq, 1);
    reg_wr(2'd2, 16'h0000, 1'b1);
    chk(!irq, "R11 clear on mode write", irq, 0);
    run_xfer(1'b0, 1'b0, 16'h0200, 5);
    run_xfer(1'b1, 1'b0, 16'h0300, 4);
    run_xfer(1'b1, 1'b1, 16'h0400, 7);
    run_xfer(1'b0, 1'b1, 16'h0500, 1);
    run_xfer(1'b1, 1'b0, 16'hFFFE, 4);

    // random mix
    for (int t = 0; t < 10; t++)
      run_xfer(1'($urandom), 1'($urandom), 16'($urandom), 1 + int'($urandom % 9));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule